// File: doc/BRIEF.md
# Address Staging Register with Modular Step

This block holds a 15-bit address value on its way into a register bank. It is split into two 6-bit characters and a 3-bit half character above them. In one clock it can do one of three things. It can load a value from one of two 15-bit source buses: the memory address bus or the memory data bus. It can add one to its contents or subtract one from them. Or it can hold what it has.

Loads come in two kinds. A whole-word load writes 12 or 15 bits, starting at bit 0, as the address mode selects. A character load writes only one character slot, using the low-order bits of the chosen source. The step operation wraps at 4096 in 12-bit mode and at 32768 in 15-bit mode. In 12-bit mode the half character is left as it was.

Top module: `stg_addr_reg`

## Requirements
- R1: While reset is asserted, and after it is released, `q_o` reads 0 until the first operation.
- R2: `src_i` = 0 selects `mar_i` as the load source and `src_i` = 1 selects `mdr_i`; the unselected bus has no effect on `q_o`.
- R3: A load with `tgt_i` = 3 (whole word) and `wide_i` = 1 writes all 15 source bits into `q_o` on the next clock.
- R4: A load with `tgt_i` = 3 and `wide_i` = 0 writes source bits [11:0] into `q_o[11:0]` and leaves `q_o[14:12]` unchanged.
- R5: A load with `tgt_i` = 0 writes source[5:0] into `q_o[5:0]`. With `tgt_i` = 1 it writes source[5:0] into `q_o[11:6]`. With `tgt_i` = 2 it writes source[2:0] into `q_o[14:12]`. All other bits are kept, and `wide_i` has no effect on these loads.
- R6: A step with `down_i` = 0 and `wide_i` = 1 sets `q_o` to (`q_o` + 1) mod 32768.
- R7: A step with `down_i` = 1 and `wide_i` = 1 sets `q_o` to (`q_o` − 1) mod 32768.
- R8: A step with `wide_i` = 0 changes `q_o[11:0]` by +1 or −1 mod 4096, as `down_i` selects, and leaves `q_o[14:12]` unchanged.
- R9: When `load_i` and `step_i` are both high, only the load takes effect.
- R10: With `load_i` and `step_i` both low, `q_o` keeps its value whatever the buses do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | Load command |
| src_i | input | 1 | Source select: 0 = address bus, 1 = data bus |
| wide_i | input | 1 | Address mode: 0 = 12-bit, 1 = 15-bit |
| tgt_i | input | 2 | Load target: 0 = low character, 1 = middle character, 2 = half character, 3 = whole word |
| step_i | input | 1 | Step (increment or decrement) command |
| down_i | input | 1 | Step direction: 0 = up, 1 = down |
| mar_i | input | 15 | Memory address bus |
| mdr_i | input | 15 | Memory data bus |
| q_o | output | 15 | Register contents |

## Verification
The bench builds the block with its default parameters: a 15-bit word, a 12-bit short mode and 6-bit characters. This gives a 3-bit half character that the 12-bit mode must protect. These values make both wrap points reachable in single steps from all-ones and all-zeros patterns. They also let a carry or borrow out of bit 11 be observed, since it must not reach bit 12 in short mode. The stimulus keeps the two source buses different, so a wrong source selection or a wrong character slot shows up directly in `q_o`.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    TGT_LO   = 2'd0,
    TGT_MID  = 2'd1,
    TGT_HALF = 2'd2,
    TGT_WORD = 2'd3
  } tgt_e;

  typedef enum logic {
    SRC_ADDR = 1'b0,
    SRC_DATA = 1'b1
  } src_e;
endpackage

// File: rtl/stg_load_path.sv
module stg_load_path
  import stg_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int SHORT_W = 12,
  parameter int CHAR_W  = 6
) (
  input  src_e              src,
  input  logic              wide,
  input  tgt_e              tgt,
  input  logic [ADDR_W-1:0] mar,
  input  logic [ADDR_W-1:0] mdr,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam int HALF_W = ADDR_W - 2*CHAR_W;

  logic [ADDR_W-1:0] srcv;
  logic [ADDR_W-1:0] word_v;

  always_comb begin
    srcv = (src == SRC_DATA) ? mdr : mar;
  end

  generate
    if (SHORT_W < ADDR_W) begin : g_short
      always_comb begin
        word_v = wide ? srcv : {cur[ADDR_W-1:SHORT_W], srcv[SHORT_W-1:0]};
      end
    end else begin : g_full
      always_comb begin
        word_v = srcv;
      end
    end
  endgenerate

  always_comb begin
    nxt = cur;
    unique case (tgt)
      TGT_LO:   nxt[CHAR_W-1:0]        = srcv[CHAR_W-1:0];
      TGT_MID:  nxt[2*CHAR_W-1:CHAR_W] = srcv[CHAR_W-1:0];
      TGT_HALF: nxt[ADDR_W-1:2*CHAR_W] = srcv[HALF_W-1:0];
      TGT_WORD: nxt                    = word_v;
      default:  nxt                    = cur;
    endcase
  end
endmodule

// File: rtl/stg_step_unit.sv
module stg_step_unit #(
  parameter int ADDR_W  = 15,
  parameter int SHORT_W = 12
) (
  input  logic              wide,
  input  logic              down,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0]  ONE_L = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [SHORT_W-1:0] ONE_S = {{(SHORT_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0]  long_v;
  logic [SHORT_W-1:0] short_v;

  always_comb begin
    long_v  = down ? (cur - ONE_L) : (cur + ONE_L);
    short_v = down ? (cur[SHORT_W-1:0] - ONE_S) : (cur[SHORT_W-1:0] + ONE_S);
  end

  generate
    if (SHORT_W < ADDR_W) begin : g_split
      always_comb begin
        nxt = wide ? long_v : {cur[ADDR_W-1:SHORT_W], short_v};
      end
    end else begin : g_same
      always_comb begin
        nxt = long_v;
      end
    end
  endgenerate
endmodule

// File: rtl/stg_addr_reg.sv
module stg_addr_reg
  import stg_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int SHORT_W = 12,
  parameter int CHAR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              src_i,
  input  logic              wide_i,
  input  logic [1:0]        tgt_i,
  input  logic              step_i,
  input  logic              down_i,
  input  logic [ADDR_W-1:0] mar_i,
  input  logic [ADDR_W-1:0] mdr_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [ADDR_W-1:0] q_r;
  logic [ADDR_W-1:0] load_v;
  logic [ADDR_W-1:0] step_v;
  logic [ADDR_W-1:0] q_nxt;
  logic              q_en;

  // reset: asserts at once, releases two clocks later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  stg_load_path #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .CHAR_W(CHAR_W)
  ) u_load (
    .src (src_e'(src_i)),
    .wide(wide_i),
    .tgt (tgt_e'(tgt_i)),
    .mar (mar_i),
    .mdr (mdr_i),
    .cur (q_r),
    .nxt (load_v)
  );

  stg_step_unit #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W)
  ) u_step (
    .wide(wide_i),
    .down(down_i),
    .cur (q_r),
    .nxt (step_v)
  );

  // next state: a load wins over a step
  always_comb begin
    q_en  = load_i | step_i;
    q_nxt = load_i ? load_v : step_v;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/stg_addr_reg_chk.sv
module stg_addr_reg_chk #(
  parameter int ADDR_W  = 15,
  parameter int SHORT_W = 12,
  parameter int CHAR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              src,
  input logic              wide,
  input logic [1:0]        tgt,
  input logic              step,
  input logic              down,
  input logic [ADDR_W-1:0] mar,
  input logic [ADDR_W-1:0] mdr,
  input logic [ADDR_W-1:0] q
);
  localparam int HALF_W = ADDR_W - 2*CHAR_W;
  logic [ADDR_W-1:0] sv;
  assign sv = src ? mdr : mar;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> q == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(q));

  p_word_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tgt == 2'd3 && wide) |=> q == $past(sv));

  p_word_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tgt == 2'd3 && !wide) |=>
      (q[SHORT_W-1:0] == $past(sv[SHORT_W-1:0]) &&
       q[ADDR_W-1:SHORT_W] == $past(q[ADDR_W-1:SHORT_W])));

  p_char_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tgt == 2'd0) |=>
      (q[CHAR_W-1:0] == $past(sv[CHAR_W-1:0]) &&
       q[ADDR_W-1:CHAR_W] == $past(q[ADDR_W-1:CHAR_W])));

  p_char_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tgt == 2'd2) |=>
      (q[ADDR_W-1:2*CHAR_W] == $past(sv[HALF_W-1:0]) &&
       q[2*CHAR_W-1:0] == $past(q[2*CHAR_W-1:0])));

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && wide && !down) |=> q == $past(q) + 1'b1);

  p_step_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && wide && down) |=> q == $past(q) - 1'b1);

  p_step_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !wide) |=> $stable(q[ADDR_W-1:SHORT_W]));
endmodule

bind stg_addr_reg stg_addr_reg_chk #(
  .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .CHAR_W(CHAR_W)
) u_chk (
  .clk(clk_i), .rst_n(rst_q), .load(load_i), .src(src_i), .wide(wide_i),
  .tgt(tgt_i), .step(step_i), .down(down_i), .mar(mar_i), .mdr(mdr_i),
  .q(q_o)
);

// File: tb/stg_addr_reg_test.sv
module stg_addr_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        load_i, src_i, wide_i, step_i, down_i;
  logic [1:0]  tgt_i;
  logic [14:0] mar_i, mdr_i;
  logic [14:0] q_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  stg_addr_reg uut (
    .clk_i, .rst_ni, .load_i, .src_i, .wide_i, .tgt_i,
    .step_i, .down_i, .mar_i, .mdr_i, .q_o
  );

  // fields: load src wide tgt step down mar mdr expected
  localparam int NV = 14;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,2'd3,1'b0,1'b0,15'h5A5A,15'h0123,15'h5A5A}, // R3 R2
    {1'b1,1'b1,1'b0,2'd3,1'b0,1'b0,15'h0000,15'h7FFF,15'h5FFF}, // R4 R2
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,15'h1111,15'h2222,15'h5000}, // R8 up wrap
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,15'h1111,15'h2222,15'h5FFF}, // R8 down wrap
    {1'b0,1'b0,1'b1,2'd0,1'b1,1'b1,15'h1111,15'h2222,15'h5FFE}, // R7
    {1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,15'h0011,15'h7FFF,15'h5FD1}, // R5 low
    {1'b1,1'b1,1'b1,2'd1,1'b0,1'b0,15'h0000,15'h7FE5,15'h5951}, // R5 mid
    {1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,15'h0002,15'h7FFF,15'h2951}, // R5 half
    {1'b1,1'b1,1'b1,2'd3,1'b1,1'b0,15'h7777,15'h1234,15'h1234}, // R9
    {1'b0,1'b1,1'b1,2'd3,1'b0,1'b0,15'h7FFF,15'h6666,15'h1234}, // R10
    {1'b1,1'b0,1'b1,2'd3,1'b0,1'b0,15'h7FFF,15'h0000,15'h7FFF}, // R3
    {1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,15'h0000,15'h0000,15'h0000}, // R6 wrap
    {1'b0,1'b0,1'b1,2'd0,1'b1,1'b1,15'h0000,15'h0000,15'h7FFF}, // R7 wrap
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,15'h0000,15'h0000,15'h7FFE}  // R8
  };
  localparam int TAG [NV] = '{3, 4, 8, 8, 7, 5, 5, 5, 9, 10, 3, 6, 7, 8};

  task automatic check(input int req, input logic [14:0] exp);
    checks++;
    if (q_o !== exp) begin
      fails++;
      $display("FAIL R%0d q_o=%h expected=%h", req, q_o, exp);
    end
  endtask

  task automatic idle();
    load_i = 0; src_i = 0; wide_i = 0; tgt_i = 0; step_i = 0; down_i = 0;
    mar_i = '0; mdr_i = '0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(1, 15'h0000);                       // R1 during reset
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(1, 15'h0000);                       // R1 after release

    for (int i = 0; i < NV; i++) begin
      {load_i, src_i, wide_i, tgt_i, step_i, down_i, mar_i, mdr_i} = VEC[i][51:15];
      @(negedge clk_i);
      check(TAG[i], VEC[i][14:0]);
    end

    // R2: unselected bus changes do not leak through a data-bus load
    load_i = 1; src_i = 1; wide_i = 1; tgt_i = 2'd3; mdr_i = 15'h0ABC; mar_i = 15'h7123;
    @(negedge clk_i);
    check(2, 15'h0ABC);
    // R5: half-character load ignores wide_i = 0
    load_i = 1; src_i = 0; wide_i = 0; tgt_i = 2'd2; mar_i = 15'h7FF5; mdr_i = 15'h0000;
    @(negedge clk_i);
    check(5, 15'h5ABC);
    // R8: borrow out of bit 11 must not reach bit 12
    load_i = 1; src_i = 0; wide_i = 1; tgt_i = 2'd3; mar_i = 15'h3000;
    @(negedge clk_i);
    load_i = 0; step_i = 1; down_i = 1; wide_i = 0;
    @(negedge clk_i);
    check(8, 15'h3FFF);
    // R1: asynchronous reset mid-run
    idle();
    #2 rst_ni = 1'b0;
    #1 check(1, 15'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(1, 15'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule